// File: doc/BRIEF.md
# Four-Channel Transfer Priority Arbiter

This block picks which of four transfer channels owns the shared bus when more than one of them asks for it at once. A two-bit mode input chooses the policy: three fixed rankings, two of which are not in channel-number order, or a rotating round-robin. The winner is held until the owning channel pulses a completion strobe. After that, arbitration runs again on the following cycle.

A global error input stops all traffic at once. While it is high, every grant output reads zero, any grant in flight is dropped, and no new winner is chosen. When the error clears, the block starts again from idle.

The mode used for a grant is sampled only at the cycle where a winner is picked. A mode change therefore never disturbs a grant that is already held. The rotation pointer moves only when a grant made under round-robin completes.

Top module: `dma_prio_arb`

## Requirements
- R1: With mode 2'b00 the winner is the requesting channel highest in the ranking 0, 1, 2, 3 (leftmost highest). Bit i of `req` and of `grant` is channel i.
- R2: With mode 2'b01 the ranking is 0, 2, 3, 1.
- R3: With mode 2'b10 the ranking is 2, 0, 1, 3.
- R4: With mode 2'b11 the search starts at the channel after the one whose round-robin grant last completed, and wraps from 3 to 0.
- R5: Reset clears `grant`, `grant_idx` and `grant_vld`, and places the rotation so that channel 0 is searched first.
- R6: A grant appears on the clock edge at which the idle block samples a request. It holds, with unchanged index, until `done` is sampled high, and drops on that edge. Arbitration resumes at the next edge.
- R7: When no channel requests, `grant_vld` is 0 and `grant` is 4'b0000.
- R8: While `addr_err` is high, `grant_vld` is 0 and `grant` is zero in the same cycle. A held grant is discarded, and no grant is issued until a clock edge at which `addr_err` is low.
- R9: The mode is taken only at the edge where a winner is picked. Changing `prio_mode` or `req` during a held grant has no effect on that grant.
- R10: Completing a grant made under a fixed mode leaves the rotation pointer unchanged.
- R11: `grant` is one-hot or zero. `grant_vld` is 1 exactly when `grant` is non-zero. `grant_idx` is the binary index of the set bit. A new grant goes only to a channel that requested at the picking edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 4 | Per-channel transfer request |
| prio_mode | input | 2 | Arbitration policy select |
| done | input | 1 | Completion strobe for the held grant |
| addr_err | input | 1 | Global error; suspends all grants |
| grant | output | 4 | One-hot grant |
| grant_idx | output | 2 | Index of the granted channel |
| grant_vld | output | 1 | A grant is active |

## Verification
A request sampled by an idle block shows on the grant outputs one edge later. A `done` sampled high clears them at that same edge, and the next winner appears one edge after that. The error mask acts without any clock delay. The bench drives every input at the falling edge and reads the outputs at the next falling edge, so each registered result is checked exactly one edge after its cause. For the error case it reads a short delay after driving, before any rising edge, to confirm the mask takes effect within the same cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int NCH  = 4;
    localparam int IDXW = $clog2(NCH);
    localparam int MODEW = 2;

    localparam logic [MODEW-1:0] MODE_RR = 2'b11;

    typedef struct packed {
        logic            busy;
        logic [NCH-1:0]  grant;
        logic [IDXW-1:0] idx;
        logic [IDXW-1:0] rr_ptr;
        logic [MODEW-1:0] mode;
    } arb_state_t;

    // Ranking for each fixed mode; slot k (bits k*IDXW) holds the k-th highest channel.
    function automatic logic [NCH*IDXW-1:0] rank_of(input int m);
        case (m)
            0:       rank_of = {2'd3, 2'd2, 2'd1, 2'd0};
            1:       rank_of = {2'd1, 2'd3, 2'd2, 2'd0};
            default: rank_of = {2'd3, 2'd1, 2'd0, 2'd2};
        endcase
    endfunction
endpackage

// File: rtl/dma_arb_fixed_pick.sv
module dma_arb_fixed_pick
    import dma_arb_pkg::*;
#(
    parameter logic [NCH*IDXW-1:0] RANK = {2'd3, 2'd2, 2'd1, 2'd0}
) (
    input  logic [NCH-1:0]  req,
    output logic            hit,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        // Walk from lowest rank up so the highest-ranked requester is written last.
        for (int k = NCH - 1; k >= 0; k--) begin
            if (req[RANK[k*IDXW +: IDXW]]) begin
                hit = 1'b1;
                idx = RANK[k*IDXW +: IDXW];
            end
        end
    end
endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick
    import dma_arb_pkg::*;
(
    input  logic [NCH-1:0]  req,
    input  logic [IDXW-1:0] ptr,
    output logic            hit,
    output logic [IDXW-1:0] idx
);
    logic [IDXW-1:0] cand;

    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        cand = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            cand = ptr + k[IDXW-1:0];
            if (req[cand]) begin
                hit = 1'b1;
                idx = cand;
            end
        end
    end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req,
    input  logic [MODEW-1:0] prio_mode,
    input  logic             done,
    input  logic             addr_err,
    output logic [NCH-1:0]   grant,
    output logic [IDXW-1:0]  grant_idx,
    output logic             grant_vld
);
    localparam int NMODE = 1 << MODEW;

    arb_state_t s_d, s_q;

    logic [NMODE-1:0] hit_m;
    logic [IDXW-1:0]  idx_m [NMODE];

    for (genvar m = 0; m < NMODE; m++) begin : g_pick
        if (m == NMODE - 1) begin : g_rr
            dma_arb_rr_pick u_rr (
                .req (req),
                .ptr (s_q.rr_ptr),
                .hit (hit_m[m]),
                .idx (idx_m[m])
            );
        end else begin : g_fixed
            dma_arb_fixed_pick #(.RANK(rank_of(m))) u_fix (
                .req (req),
                .hit (hit_m[m]),
                .idx (idx_m[m])
            );
        end
    end

    always_comb begin
        s_d = s_q;
        if (addr_err) begin
            s_d.busy  = 1'b0;
            s_d.grant = '0;
        end else if (s_q.busy) begin
            if (done) begin
                s_d.busy  = 1'b0;
                s_d.grant = '0;
                if (s_q.mode == MODE_RR) begin
                    s_d.rr_ptr = s_q.idx + 1'b1;
                end
            end
        end else if (hit_m[prio_mode]) begin
            s_d.busy  = 1'b1;
            s_d.idx   = idx_m[prio_mode];
            s_d.grant = NCH'(1) << idx_m[prio_mode];
            s_d.mode  = prio_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_vld = s_q.busy & ~addr_err;
    assign grant     = addr_err ? '0 : s_q.grant;
    assign grant_idx = addr_err ? '0 : s_q.idx;
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk
    import dma_arb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   req,
    input logic [MODEW-1:0] prio_mode,
    input logic             done,
    input logic             addr_err,
    input logic [NCH-1:0]   grant,
    input logic [IDXW-1:0]  grant_idx,
    input logic             grant_vld
);
    assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant_vld == (grant != '0)));

    assert_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> grant[grant_idx]);

    assert_requester_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_vld && !addr_err) |=> (!grant_vld || (($past(req) & grant) != '0)));

    assert_err_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> !grant_vld);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !done) |=> (addr_err || (grant_vld && $stable(grant_idx))));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && done) |=> !grant_vld);

    assert_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_vld && !addr_err && req != '0) |=> (grant_vld || addr_err));

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_vld && req == '0) |=> !grant_vld);
endmodule

bind dma_prio_arb dma_prio_arb_chk u_chk (.*);

// File: tb/dma_prio_arb_tb.sv
module dma_prio_arb_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // {mode[7:6], req[5:2], expected index[1:0]}
    localparam logic [7:0] VEC [NVEC] = '{
        {2'b00, 4'b1111, 2'd0}, {2'b00, 4'b1110, 2'd1},
        {2'b00, 4'b1100, 2'd2}, {2'b00, 4'b1000, 2'd3},
        {2'b01, 4'b1111, 2'd0}, {2'b01, 4'b1110, 2'd2},
        {2'b01, 4'b1010, 2'd3}, {2'b01, 4'b0010, 2'd1},
        {2'b10, 4'b1111, 2'd2}, {2'b10, 4'b1011, 2'd0},
        {2'b10, 4'b1010, 2'd1}, {2'b10, 4'b1000, 2'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [1:0] prio_mode = '0;
    logic       done = 1'b0;
    logic       addr_err = 1'b0;
    logic [3:0] grant;
    logic [1:0] grant_idx;
    logic       grant_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_prio_arb u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .prio_mode (prio_mode),
        .done      (done),
        .addr_err  (addr_err),
        .grant     (grant),
        .grant_idx (grant_idx),
        .grant_vld (grant_vld)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int seen();
        return grant_vld ? int'(grant_idx) : -1;
    endfunction

    task automatic expect_grant(input int e, input string tag);
        check(grant_vld && grant_idx == e[1:0] && grant == (4'b1 << e), tag, seen(), e);
    endtask

    task automatic expect_none(input string tag);
        check(!grant_vld && grant == 4'b0000, tag, seen(), -1);
    endtask

    // Request, check the grant one edge later, complete it, return to idle.
    task automatic arb_once(input logic [1:0] m, input logic [3:0] r, input int e, input string tag);
        prio_mode = m;
        req = r;
        @(negedge clk);
        expect_grant(e, tag);
        done = 1'b1;
        @(negedge clk);
        expect_none({tag, " release"});
        done = 1'b0;
        req = '0;
        @(negedge clk);
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R2";
            default: return "R3";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        req = 4'b1111;
        repeat (3) @(negedge clk);
        expect_none("R5 reset outputs");
        req = '0;
        rst_n = 1'b1;
        @(negedge clk);

        // R5, R4: rotation from reset state
        arb_once(2'b11, 4'b1111, 0, "R5 rr start at ch0");
        arb_once(2'b11, 4'b1111, 1, "R4 rr after ch0");
        arb_once(2'b11, 4'b1111, 2, "R4 rr after ch1");
        arb_once(2'b11, 4'b1111, 3, "R4 rr after ch2");
        arb_once(2'b11, 4'b1111, 0, "R4 rr wrap 3 to 0");
        arb_once(2'b11, 4'b1001, 3, "R4 rr skip to ch3");
        arb_once(2'b11, 4'b0110, 1, "R4 rr wrap search");
        // R10: fixed-mode completion leaves pointer at ch2
        arb_once(2'b00, 4'b1000, 3, "R10 fixed grant");
        arb_once(2'b11, 4'b1111, 2, "R10 pointer unchanged");

        // Table of fixed rankings: R1, R2, R3
        for (int i = 0; i < NVEC; i++) begin
            arb_once(VEC[i][7:6], VEC[i][5:2], int'(VEC[i][1:0]), mode_tag(VEC[i][7:6]));
        end

        // R7: no requests
        req = '0;
        prio_mode = 2'b00;
        repeat (2) @(negedge clk);
        expect_none("R7 idle");

        // R6, R9: hold across mode and request changes
        prio_mode = 2'b00;
        req = 4'b1010;
        @(negedge clk);
        expect_grant(1, "R6 grant after one edge");
        prio_mode = 2'b10;
        req = 4'b1111;
        @(negedge clk);
        expect_grant(1, "R9 hold after mode change");
        @(negedge clk);
        expect_grant(1, "R6 hold without done");
        done = 1'b1;
        @(negedge clk);
        expect_none("R6 drop on done");
        done = 1'b0;
        @(negedge clk);
        expect_grant(2, "R9 new mode at next pick");
        done = 1'b1;
        req = '0;
        @(negedge clk);
        done = 1'b0;
        @(negedge clk);

        // R8: error suspends
        prio_mode = 2'b00;
        req = 4'b0001;
        @(negedge clk);
        expect_grant(0, "R8 pre-error grant");
        addr_err = 1'b1;
        #1;
        expect_none("R8 immediate mask");
        @(negedge clk);
        expect_none("R8 held while error");
        req = 4'b0100;
        @(negedge clk);
        expect_none("R8 no new grant under error");
        addr_err = 1'b0;
        #1;
        expect_none("R8 discarded grant stays gone");
        @(negedge clk);
        expect_grant(2, "R8 resume after clear");
        done = 1'b1;
        req = '0;
        @(negedge clk);
        done = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule